// File: doc/BRIEF.md
# Active List with In-Order Commit and Rollback

This block keeps a program-ordered record of every in-flight instruction in an out-of-order core that uses a unified physical register file. At dispatch an instruction takes the entry at the tail. The entry holds the instruction's PC, whether it writes a register, the logical destination number and the physical register that held that logical register before this instruction renamed it. The allocated entry index goes back to the dispatch stage. Execution units later report completion against that index, in any order, and can flag an exception.

Entries leave from the head strictly in program order, one per cycle, once they are done. A retiring entry hands its old physical register to the free list, because no later reader can name that register any more. When the head entry carries an exception flag, it does not retire. The block enters a rollback walk instead. The walk starts at the youngest entry and moves toward the head, producing up to `UNDO_W` undo writes per cycle. Each undo write tells the rename map to point a logical register back at its old physical register. When the walk has covered the faulting entry, the list is empty and a one-cycle recovery pulse carries the faulting PC. `DEPTH` must be a power of two.

Top module: `active_list`

## Requirements
- R1: After reset the list is empty, `disp_ready` is 1, `disp_idx` is 0, and `ret_valid`, `free_valid`, `undo_valid` and `rec_done` are all 0.
- R2: Each accepted dispatch occupies the entry whose index `disp_idx` showed in that cycle. Successive dispatches take consecutive indices, modulo `DEPTH`.
- R3: When `DEPTH` entries are in flight, `disp_ready` is 0 and a dispatch request is not stored: it never retires and takes no index.
- R4: Entries retire in program order, at most one per cycle, and only after they and all older entries have completed. If the head entry completes in cycle k, `ret_valid` with its `ret_pc` appears after edge k+1.
- R5: A retiring entry that writes a register raises `free_valid` together with `ret_valid`, and `free_preg` equals the stored old physical register. A retiring entry without a destination raises no `free_valid`.
- R6: A completed head entry with its exception flag set does not retire and frees nothing. Rollback starts on the next edge, and `disp_ready` stays 0 from that decision until the walk ends.
- R7: The walk undoes entries from the youngest toward the head, `UNDO_W` per cycle. Lane 0 of `undo_valid`/`undo_ldst`/`undo_preg` carries the youngest entry of the group. A lane's logical number sits at bits [i*LREG_W +: LREG_W] and its register at [i*PREG_W +: PREG_W]. A lane whose entry has no destination, or lies beyond the head, has its `undo_valid` bit at 0.
- R8: `rec_done` pulses for one cycle together with the last undo group, and `rec_pc` holds the faulting entry's PC. After that the list is empty, dispatch is open again, and the next allocated index is the faulting entry's index.
- R9: An exception flag on an entry that is not at the head has no effect until every older entry has retired normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request |
| disp_pc | input | PC_W | PC of dispatching instruction |
| disp_has_dst | input | 1 | Instruction writes a register |
| disp_ldst | input | LREG_W | Logical destination number |
| disp_old_preg | input | PREG_W | Physical register previously mapped to the destination |
| disp_ready | output | 1 | Dispatch can be accepted this cycle |
| disp_idx | output | log2(DEPTH) | Index the next accepted dispatch occupies |
| cmpl_valid | input | 1 | Completion report |
| cmpl_idx | input | log2(DEPTH) | Entry being completed |
| cmpl_exc | input | 1 | Completion raised an exception |
| ret_valid | output | 1 | An entry retired |
| ret_pc | output | PC_W | PC of retired entry |
| free_valid | output | 1 | A physical register returns to the free list |
| free_preg | output | PREG_W | Returned physical register |
| undo_valid | output | UNDO_W | Per-lane undo write enable |
| undo_ldst | output | UNDO_W*LREG_W | Per-lane logical register to restore |
| undo_preg | output | UNDO_W*PREG_W | Per-lane physical register to restore |
| rec_done | output | 1 | Rollback finished (one-cycle pulse) |
| rec_pc | output | PC_W | PC of the faulting instruction |
| empty | output | 1 | No entries in flight |

## Verification
The properties assume that a completion names only an entry that is in flight and not yet completed, with at most one report per cycle. They also assume that no completion arrives for an entry after the walk has started. The bench keeps to this by tracking which indices it has allocated and completed. It completes each index exactly once, and it sends no completion while a rollback is under way. Dispatch requests are offered even while `disp_ready` is low, since the block must ignore those on its own.

// File: rtl/al_pkg.sv
package al_pkg;
  typedef enum logic [0:0] {
    AL_RUN  = 1'b0,
    AL_WALK = 1'b1
  } al_mode_e;
endpackage

// File: rtl/al_ptrs.sv
module al_ptrs #(
  parameter  int DEPTH = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_en,
  input  logic             retire_en,
  input  logic             collapse_en,
  output logic [PTR_W-1:0] head_ptr,
  output logic [PTR_W-1:0] tail_ptr,
  output logic             is_empty,
  output logic             is_full
);
  logic [PTR_W-1:0] head_q, tail_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (retire_en) head_q <= head_q + PTR_W'(1);
      if (collapse_en)   tail_q <= head_q;
      else if (alloc_en) tail_q <= tail_q + PTR_W'(1);
    end
  end

  assign head_ptr = head_q;
  assign tail_ptr = tail_q;
  assign is_empty = (head_q == tail_q);
  assign is_full  = (head_q[IDX_W] != tail_q[IDX_W]) &&
                    (head_q[IDX_W-1:0] == tail_q[IDX_W-1:0]);
endmodule

// File: rtl/al_entry_ram.sv
module al_entry_ram #(
  parameter  int DEPTH = 32,
  parameter  int ENT_W = 44,
  parameter  int RD_N  = 5,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      we,
  input  logic [IDX_W-1:0]          waddr,
  input  logic [ENT_W-1:0]          wdata,
  input  logic [RD_N-1:0][IDX_W-1:0] raddr,
  output logic [RD_N-1:0][ENT_W-1:0] rdata
);
  logic [ENT_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar r = 0; r < RD_N; r++) begin : g_rd
    assign rdata[r] = mem[raddr[r]];
  end
endmodule

// File: rtl/al_flags.sv
module al_flags #(
  parameter  int DEPTH = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_en,
  input  logic [IDX_W-1:0] alloc_idx,
  input  logic             cmpl_en,
  input  logic [IDX_W-1:0] cmpl_idx,
  input  logic             cmpl_exc,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_done,
  output logic             rd_exc
);
  logic [DEPTH-1:0] done_q, exc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= '0;
      exc_q  <= '0;
    end else begin
      if (alloc_en) begin
        done_q[alloc_idx] <= 1'b0;
        exc_q[alloc_idx]  <= 1'b0;
      end
      if (cmpl_en) begin
        done_q[cmpl_idx] <= 1'b1;
        exc_q[cmpl_idx]  <= cmpl_exc;
      end
    end
  end

  assign rd_done = done_q[rd_idx];
  assign rd_exc  = exc_q[rd_idx];
endmodule

// File: rtl/al_undo_walk.sv
module al_undo_walk #(
  parameter  int IDX_W  = 5,
  parameter  int UNDO_W = 4,
  localparam int PTR_W  = IDX_W + 1
) (
  input  logic [PTR_W-1:0]              walk_ptr,
  input  logic [PTR_W-1:0]              head_ptr,
  output logic [UNDO_W-1:0][IDX_W-1:0]  lane_addr,
  output logic [UNDO_W-1:0]             lane_live,
  output logic                          last_group,
  output logic [PTR_W-1:0]              next_walk
);
  logic [PTR_W-1:0] remaining;

  assign remaining  = walk_ptr - head_ptr;
  assign last_group = (remaining <= PTR_W'(UNDO_W));
  assign next_walk  = walk_ptr - PTR_W'(UNDO_W);

  for (genvar g = 0; g < UNDO_W; g++) begin : g_lane
    logic [PTR_W-1:0] pos;
    assign pos          = walk_ptr - PTR_W'(g + 1);
    assign lane_addr[g] = pos[IDX_W-1:0];
    assign lane_live[g] = (remaining > PTR_W'(g));
  end
endmodule

// File: rtl/active_list.sv
module active_list
  import al_pkg::*;
#(
  parameter  int DEPTH  = 32,
  parameter  int PC_W   = 32,
  parameter  int LREG_W = 5,
  parameter  int PREG_W = 6,
  parameter  int UNDO_W = 4,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     disp_valid,
  input  logic [PC_W-1:0]          disp_pc,
  input  logic                     disp_has_dst,
  input  logic [LREG_W-1:0]        disp_ldst,
  input  logic [PREG_W-1:0]        disp_old_preg,
  output logic                     disp_ready,
  output logic [IDX_W-1:0]         disp_idx,
  input  logic                     cmpl_valid,
  input  logic [IDX_W-1:0]         cmpl_idx,
  input  logic                     cmpl_exc,
  output logic                     ret_valid,
  output logic [PC_W-1:0]          ret_pc,
  output logic                     free_valid,
  output logic [PREG_W-1:0]        free_preg,
  output logic [UNDO_W-1:0]        undo_valid,
  output logic [UNDO_W*LREG_W-1:0] undo_ldst,
  output logic [UNDO_W*PREG_W-1:0] undo_preg,
  output logic                     rec_done,
  output logic [PC_W-1:0]          rec_pc,
  output logic                     empty
);
  localparam int PTR_W   = IDX_W + 1;
  localparam int ENT_W   = 1 + LREG_W + PREG_W + PC_W;
  localparam int RD_N    = UNDO_W + 1;
  localparam int PREG_LO = PC_W;
  localparam int LDST_LO = PC_W + PREG_W;
  localparam int HAS_BIT = ENT_W - 1;

  al_mode_e mode_q;
  logic     walking;

  logic [PTR_W-1:0] head_ptr, tail_ptr, walk_q, next_walk;
  logic             empty_w, full_w;
  logic             head_done, head_exc;
  logic             head_ready, commit_en, start_walk, finish_walk, accept;
  logic [PC_W-1:0]  fault_pc_q;

  logic [RD_N-1:0][IDX_W-1:0]   rd_addr;
  logic [RD_N-1:0][ENT_W-1:0]   rd_data;
  logic [UNDO_W-1:0][IDX_W-1:0] lane_addr;
  logic [UNDO_W-1:0]            lane_live;
  logic                         last_group;
  logic [ENT_W-1:0]             head_ent;

  // ---------------- control decisions ----------------
  assign walking     = (mode_q == AL_WALK);
  assign head_ent    = rd_data[0];
  assign head_ready  = !walking && !empty_w && head_done;
  assign commit_en   = head_ready && !head_exc;
  assign start_walk  = head_ready && head_exc;
  assign finish_walk = walking && last_group;
  assign disp_ready  = !walking && !full_w && !start_walk;
  assign accept      = disp_valid && disp_ready;
  assign disp_idx    = tail_ptr[IDX_W-1:0];
  assign empty       = empty_w;

  // ---------------- pointers ----------------
  al_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk         (clk),
    .rst         (rst),
    .alloc_en    (accept),
    .retire_en   (commit_en),
    .collapse_en (finish_walk),
    .head_ptr    (head_ptr),
    .tail_ptr    (tail_ptr),
    .is_empty    (empty_w),
    .is_full     (full_w)
  );

  // ---------------- per-entry status bits ----------------
  al_flags #(.DEPTH(DEPTH)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .alloc_en  (accept),
    .alloc_idx (tail_ptr[IDX_W-1:0]),
    .cmpl_en   (cmpl_valid),
    .cmpl_idx  (cmpl_idx),
    .cmpl_exc  (cmpl_exc),
    .rd_idx    (head_ptr[IDX_W-1:0]),
    .rd_done   (head_done),
    .rd_exc    (head_exc)
  );

  // ---------------- rollback lane addressing ----------------
  al_undo_walk #(.IDX_W(IDX_W), .UNDO_W(UNDO_W)) u_walk (
    .walk_ptr   (walk_q),
    .head_ptr   (head_ptr),
    .lane_addr  (lane_addr),
    .lane_live  (lane_live),
    .last_group (last_group),
    .next_walk  (next_walk)
  );

  assign rd_addr[0] = head_ptr[IDX_W-1:0];
  for (genvar g = 0; g < UNDO_W; g++) begin : g_rdmap
    assign rd_addr[g+1] = lane_addr[g];
  end

  // ---------------- entry payload storage ----------------
  al_entry_ram #(.DEPTH(DEPTH), .ENT_W(ENT_W), .RD_N(RD_N)) u_ram (
    .clk   (clk),
    .we    (accept),
    .waddr (tail_ptr[IDX_W-1:0]),
    .wdata ({disp_has_dst, disp_ldst, disp_old_preg, disp_pc}),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  // ---------------- mode and walk pointer ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= AL_RUN;
      walk_q     <= '0;
      fault_pc_q <= '0;
    end else if (start_walk) begin
      mode_q     <= AL_WALK;
      walk_q     <= tail_ptr;
      fault_pc_q <= head_ent[PC_W-1:0];
    end else if (walking) begin
      if (last_group) mode_q <= AL_RUN;
      else            walk_q <= next_walk;
    end
  end

  // ---------------- registered outputs ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      ret_valid  <= 1'b0;
      ret_pc     <= '0;
      free_valid <= 1'b0;
      free_preg  <= '0;
      rec_done   <= 1'b0;
      rec_pc     <= '0;
      undo_valid <= '0;
      undo_ldst  <= '0;
      undo_preg  <= '0;
    end else begin
      ret_valid  <= commit_en;
      ret_pc     <= head_ent[PC_W-1:0];
      free_valid <= commit_en && head_ent[HAS_BIT];
      free_preg  <= head_ent[PREG_LO +: PREG_W];
      rec_done   <= finish_walk;
      rec_pc     <= fault_pc_q;
      for (int g = 0; g < UNDO_W; g++) begin
        undo_valid[g]                 <= walking && lane_live[g] && rd_data[g+1][HAS_BIT];
        undo_ldst[g*LREG_W +: LREG_W] <= rd_data[g+1][LDST_LO +: LREG_W];
        undo_preg[g*PREG_W +: PREG_W] <= rd_data[g+1][PREG_LO +: PREG_W];
      end
    end
  end
endmodule

// File: rtl/active_list_chk.sv
module active_list_chk #(
  parameter  int DEPTH  = 32,
  parameter  int UNDO_W = 4,
  localparam int PTR_W  = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              disp_ready,
  input logic              ret_valid,
  input logic              free_valid,
  input logic [UNDO_W-1:0] undo_valid,
  input logic              rec_done,
  input logic              empty,
  input logic              walking,
  input logic [PTR_W-1:0]  head_ptr,
  input logic [PTR_W-1:0]  tail_ptr
);
  // R6
  ret_undo_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(ret_valid && (|undo_valid)));

  // R5
  free_with_ret_chk: assert property (@(posedge clk) disable iff (rst)
    free_valid |-> ret_valid);

  // R8
  rec_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rec_done |=> !rec_done);

  // R8
  rec_empty_chk: assert property (@(posedge clk) disable iff (rst)
    rec_done |-> empty);

  // R6
  walk_block_chk: assert property (@(posedge clk) disable iff (rst)
    walking |-> !disp_ready);

  // R3
  occupancy_chk: assert property (@(posedge clk) disable iff (rst)
    PTR_W'(tail_ptr - head_ptr) <= PTR_W'(DEPTH));
endmodule

bind active_list active_list_chk #(.DEPTH(DEPTH), .UNDO_W(UNDO_W)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .disp_ready (disp_ready),
  .ret_valid  (ret_valid),
  .free_valid (free_valid),
  .undo_valid (undo_valid),
  .rec_done   (rec_done),
  .empty      (empty),
  .walking    (walking),
  .head_ptr   (head_ptr),
  .tail_ptr   (tail_ptr)
);

// File: tb/test_active_list.sv
module test_active_list;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 32;
  localparam int PC_W   = 32;
  localparam int LREG_W = 5;
  localparam int PREG_W = 6;
  localparam int UNDO_W = 4;
  localparam int IDX_W  = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic disp_valid = 1'b0, disp_has_dst = 1'b0;
  logic [PC_W-1:0] disp_pc = '0;
  logic [LREG_W-1:0] disp_ldst = '0;
  logic [PREG_W-1:0] disp_old_preg = '0;
  logic disp_ready;
  logic [IDX_W-1:0] disp_idx;
  logic cmpl_valid = 1'b0, cmpl_exc = 1'b0;
  logic [IDX_W-1:0] cmpl_idx = '0;
  logic ret_valid, free_valid, rec_done, empty;
  logic [PC_W-1:0] ret_pc, rec_pc;
  logic [PREG_W-1:0] free_preg;
  logic [UNDO_W-1:0] undo_valid;
  logic [UNDO_W*LREG_W-1:0] undo_ldst;
  logic [UNDO_W*PREG_W-1:0] undo_preg;

  int n_chk = 0;
  int n_fail = 0;
  logic [PC_W-1:0]   ret_log [256];
  logic [PREG_W-1:0] free_log [256];
  int ret_n = 0;
  int free_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  active_list #(.DEPTH(DEPTH), .PC_W(PC_W), .LREG_W(LREG_W), .PREG_W(PREG_W),
                .UNDO_W(UNDO_W)) i_active_list (
    .clk(clk), .rst(rst),
    .disp_valid(disp_valid), .disp_pc(disp_pc), .disp_has_dst(disp_has_dst),
    .disp_ldst(disp_ldst), .disp_old_preg(disp_old_preg),
    .disp_ready(disp_ready), .disp_idx(disp_idx),
    .cmpl_valid(cmpl_valid), .cmpl_idx(cmpl_idx), .cmpl_exc(cmpl_exc),
    .ret_valid(ret_valid), .ret_pc(ret_pc),
    .free_valid(free_valid), .free_preg(free_preg),
    .undo_valid(undo_valid), .undo_ldst(undo_ldst), .undo_preg(undo_preg),
    .rec_done(rec_done), .rec_pc(rec_pc), .empty(empty)
  );

  // event logger, samples just after each rising edge
  always @(posedge clk) begin
    #1;
    if (!rst && ret_valid && ret_n < 256) begin
      ret_log[ret_n] = ret_pc;
      ret_n++;
    end
    if (!rst && free_valid && free_n < 256) begin
      free_log[free_n] = free_preg;
      free_n++;
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic dispatch(input logic [PC_W-1:0] pc, input logic has,
                          input logic [LREG_W-1:0] ld, input logic [PREG_W-1:0] pr,
                          output logic [IDX_W-1:0] idx);
    disp_valid = 1'b1; disp_pc = pc; disp_has_dst = has;
    disp_ldst = ld; disp_old_preg = pr;
    idx = disp_idx;
    @(negedge clk);
    disp_valid = 1'b0;
  endtask

  task automatic complete(input logic [IDX_W-1:0] idx, input logic exc);
    cmpl_valid = 1'b1; cmpl_idx = idx; cmpl_exc = exc;
    @(negedge clk);
    cmpl_valid = 1'b0; cmpl_exc = 1'b0;
  endtask

  function automatic logic [LREG_W-1:0] lane_ld(input int i);
    return undo_ldst[i*LREG_W +: LREG_W];
  endfunction
  function automatic logic [PREG_W-1:0] lane_pr(input int i);
    return undo_preg[i*PREG_W +: PREG_W];
  endfunction

  task automatic t_reset();
    chk("R1", "empty", empty, 1);
    chk("R1", "disp_ready", disp_ready, 1);
    chk("R1", "disp_idx", disp_idx, 0);
    chk("R1", "ret/free/rec", {ret_valid, free_valid, rec_done}, 0);
    chk("R1", "undo_valid", undo_valid, 0);
  endtask

  task automatic t_inorder();
    logic [IDX_W-1:0] ix;
    int rb = ret_n, fb = free_n;
    dispatch(32'h100, 1'b1, 5'd1, 6'd40, ix); chk("R2", "idx a", ix, 0);
    dispatch(32'h104, 1'b0, 5'd2, 6'd41, ix); chk("R2", "idx b", ix, 1);
    dispatch(32'h108, 1'b1, 5'd3, 6'd42, ix); chk("R2", "idx c", ix, 2);
    complete(2, 1'b0);
    idle(3);
    chk("R4", "no retire while head pending", ret_n - rb, 0);
    complete(0, 1'b0);
    chk("R4", "ret_valid same edge as completion", ret_valid, 0);
    idle(1);
    chk("R4", "ret_valid one edge later", ret_valid, 1);
    chk("R4", "ret_pc", ret_pc, 32'h100);
    chk("R5", "free_valid", free_valid, 1);
    chk("R5", "free_preg", free_preg, 40);
    complete(1, 1'b0);
    idle(4);
    chk("R4", "retire count", ret_n - rb, 3);
    chk("R4", "order 2nd", ret_log[rb+1], 32'h104);
    chk("R4", "order 3rd", ret_log[rb+2], 32'h108);
    chk("R5", "free count skips no-dst", free_n - fb, 2);
    chk("R5", "second freed reg", free_log[fb+1], 42);
    chk("R4", "empty after drain", empty, 1);
  endtask

  task automatic t_full();
    logic [IDX_W-1:0] ix;
    int rb = ret_n, bad = 0, dead = 0;
    for (int i = 0; i < DEPTH; i++) begin
      dispatch(32'h1000 + 32'(4*i), 1'b1, LREG_W'(i % 31 + 1), PREG_W'(i), ix);
      if (ix != IDX_W'((3 + i) % DEPTH)) bad++;
    end
    chk("R2", "wrapped index mismatches", bad, 0);
    chk("R3", "disp_ready when full", disp_ready, 0);
    disp_valid = 1'b1; disp_pc = 32'hDEAD; disp_has_dst = 1'b1;
    idle(2);
    disp_valid = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) complete(IDX_W'((3 + i) % DEPTH), 1'b0);
    idle(40);
    chk("R3", "retired count", ret_n - rb, DEPTH);
    chk("R3", "last retired pc", ret_log[ret_n-1], 32'h1000 + 32'(4*(DEPTH-1)));
    for (int i = rb; i < ret_n; i++) if (ret_log[i] == 32'hDEAD) dead++;
    chk("R3", "rejected request retired", dead, 0);
    chk("R3", "next index unchanged", disp_idx, 3);
  endtask

  task automatic t_rollback();
    logic [IDX_W-1:0] ix;
    int rb = ret_n, fb = free_n;
    for (int i = 0; i < 7; i++)
      dispatch(32'h200 + 32'(4*i), (i != 4), LREG_W'(i + 1), PREG_W'(50 + i), ix);
    complete(4, 1'b1);
    for (int i = 5; i <= 9; i++) complete(IDX_W'(i), 1'b0);
    idle(3);
    chk("R9", "no rollback before head retires", rec_done, 0);
    chk("R9", "dispatch still open", disp_ready, 1);
    chk("R9", "nothing retired yet", ret_n - rb, 0);
    complete(3, 1'b0);
    idle(1);
    chk("R9", "older entry retires", ret_valid, 1);
    chk("R9", "older entry pc", ret_pc, 32'h200);
    idle(1);
    chk("R6", "dispatch blocked at walk start", disp_ready, 0);
    chk("R6", "faulting entry not retired", ret_valid, 0);
    idle(1);
    chk("R7", "group1 lanes", undo_valid, 4'b1011);
    chk("R7", "lane0 ldst", lane_ld(0), 7);
    chk("R7", "lane0 preg", lane_pr(0), 56);
    chk("R7", "lane1 ldst", lane_ld(1), 6);
    chk("R7", "lane3 preg", lane_pr(3), 53);
    chk("R8", "no pulse mid-walk", rec_done, 0);
    chk("R6", "blocked mid-walk", disp_ready, 0);
    idle(1);
    chk("R7", "group2 lanes", undo_valid, 4'b0011);
    chk("R7", "g2 lane0 ldst", lane_ld(0), 3);
    chk("R7", "g2 lane1 preg", lane_pr(1), 51);
    chk("R8", "rec_done", rec_done, 1);
    chk("R8", "rec_pc", rec_pc, 32'h204);
    idle(1);
    chk("R8", "pulse width", rec_done, 0);
    chk("R8", "empty after", empty, 1);
    chk("R8", "dispatch reopened", disp_ready, 1);
    chk("R8", "next idx = faulting idx", disp_idx, 4);
    chk("R6", "only older entry freed", free_n - fb, 1);
    chk("R6", "only older entry retired", ret_n - rb, 1);
  endtask

  task automatic t_single();
    logic [IDX_W-1:0] ix;
    int rb;
    dispatch(32'h300, 1'b1, 5'd9, 6'd60, ix);
    chk("R2", "index after recovery", ix, 4);
    complete(ix, 1'b1);
    idle(1);
    chk("R6", "blocked", disp_ready, 0);
    idle(1);
    chk("R7", "single lane", undo_valid, 4'b0001);
    chk("R7", "single ldst", lane_ld(0), 9);
    chk("R7", "single preg", lane_pr(0), 60);
    chk("R8", "single rec_done", rec_done, 1);
    chk("R8", "single rec_pc", rec_pc, 32'h300);
    idle(1);
    rb = ret_n;
    dispatch(32'h304, 1'b0, 5'd0, 6'd0, ix);
    chk("R8", "reuse index", ix, 4);
    complete(ix, 1'b0);
    idle(3);
    chk("R4", "retire after recovery", ret_n - rb, 1);
    chk("R4", "retire pc after recovery", ret_log[ret_n-1], 32'h304);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    t_reset();
    t_inorder();
    t_full();
    t_rollback();
    t_single();
    summary();
    $finish;
  end
endmodule